// File: doc/BRIEF.md
# Receive DMA Process Sequencer

This block is the control sequencer of a receive DMA engine that walks a ring of receive descriptors. Once started, it asks for the descriptor at the current ring index and looks at the ownership flag that comes back. If the DMA owns the descriptor, the block waits for a frame, moves the frame's data from the receive buffer into host memory, and closes the descriptor. It can also write a timestamp before the close. It then fetches the next entry. If the host owns the descriptor, the block suspends until the host posts a poll demand or a new frame arrives.

A frame may span several descriptors, one buffer each. After the first descriptor of a frame is closed, the next descriptor is fetched and the transfer goes on without waiting for another frame. The block drives its state as a fixed 3-bit code that software can read. It also emits one-cycle event pulses for these cases:
- buffer unavailable
- process stopped
- receive complete
- early receive

The memory bus and the receive buffer are outside this block. It only sequences them through handshakes.

Top module: `rx_dma_seq`

## Requirements
- R1: The state code on `state_o` is one of: 000 stopped, 001 fetching descriptor, 011 waiting for frame, 100 suspended, 101 closing descriptor, 110 timestamp write, 111 transferring data. Code 010 never appears. After reset the code is 000, `desc_idx_o` is 0, and no event output is high.
- R2: In the stopped state, `start_i` without `stop_i` moves the block to fetching on the next cycle. While fetching, `fetch_req_o` is 1. In the stopped state every other input is ignored. If `start_i` and `stop_i` are high together, the block stays stopped.
- R3: A fetch acknowledge with `fetch_own_i`=1 (DMA-owned) moves the block to waiting. If the block is in the middle of a multi-descriptor frame, the same acknowledge moves it straight to transferring instead.
- R4: A fetch acknowledge with `fetch_own_i`=0 (host-owned) moves the block to suspended. `ru_evt_o` pulses in the first suspended cycle only if the previously acknowledged descriptor had `fetch_own_i`=1. After reset, this "previous descriptor" counts as DMA-owned.
- R5: The block stays suspended until `poll_i` or `frame_avail_i` is seen. On the next cycle it returns to fetching the same ring index.
- R6: While waiting, `frame_avail_i` moves the block to transferring. It stays there until `xfer_done_i`. If `xfer_eof_i`=0 at that point, the block closes the descriptor and the next fetch leads straight back to transferring.
- R7: When `xfer_done_i` comes with `xfer_eof_i`=1 and `ts_en_i`=1, the block spends exactly one cycle in timestamp write and then closes. Otherwise it goes straight from transferring to closing.
- R8: Closing lasts one cycle and is followed by fetching, so the block keeps running. `rc_evt_o` pulses in the cycle after a close when that descriptor ended the frame and its `fetch_irq_dis_i` flag was 0 when it was fetched.
- R9: `early_evt_o` pulses in the closing cycle of the first descriptor of a frame when that descriptor did not end the frame.
- R10: `stop_i` takes effect at the next state boundary:
  - In waiting or suspended, it takes effect at once.
  - In fetching, it takes effect at the acknowledge.
  - In transfer, the transfer is finished first and the stop takes effect after the close.
  
  `stop_evt_o` pulses in the first stopped cycle. It never pulses for a stop given while the block is already stopped.
- R11: `desc_idx_o` advances by one on each close and wraps to 0 after entry `RING_ENTRIES`-1. It is unchanged by fetches, suspension, stop and start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start command |
| stop_i | input | 1 | Stop command |
| poll_i | input | 1 | Poll-demand strobe |
| ts_en_i | input | 1 | Timestamp write enable |
| fetch_req_o | output | 1 | Descriptor fetch request |
| fetch_ack_i | input | 1 | Descriptor fetch complete |
| fetch_own_i | input | 1 | Fetched descriptor is DMA-owned |
| fetch_irq_dis_i | input | 1 | Fetched descriptor suppresses the receive-complete event |
| frame_avail_i | input | 1 | Incoming frame available |
| xfer_done_i | input | 1 | Buffer data transfer complete |
| xfer_eof_i | input | 1 | Completed buffer ends the frame |
| state_o | output | 3 | Process state code |
| desc_idx_o | output | IDX_W | Current ring index |
| ru_evt_o | output | 1 | Buffer-unavailable pulse |
| stop_evt_o | output | 1 | Process-stopped pulse |
| rc_evt_o | output | 1 | Receive-complete pulse |
| early_evt_o | output | 1 | Early-receive pulse |

## Verification
The assertions take two things for granted about the inputs:
- `fetch_ack_i` is high only while `fetch_req_o` is high.
- `xfer_done_i` and `xfer_eof_i` are high only in the transferring state.

The bench acts as the memory side. It raises each acknowledge and done strobe for exactly one cycle, and only after it has seen the matching state code. Frame-available, poll and stop commands are applied only in the states under test. The bench sweeps every combination of timestamp enable, interrupt-disable flag and frames of one to three buffers, then covers the suspend and stop paths.

// File: rtl/rx_dma_pkg.sv
package rx_dma_pkg;
  typedef enum logic [2:0] {
    RX_STOPPED = 3'b000,
    RX_FETCH   = 3'b001,
    RX_WAIT    = 3'b011,
    RX_SUSP    = 3'b100,
    RX_CLOSE   = 3'b101,
    RX_TSWR    = 3'b110,
    RX_XFER    = 3'b111
  } rx_state_e;
endpackage

// File: rtl/rx_ring_ptr.sv
module rx_ring_ptr #(
  parameter int unsigned RING_ENTRIES = 5,
  localparam int unsigned IDX_W = (RING_ENTRIES > 1) ? $clog2(RING_ENTRIES) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             adv_i,
  output logic [IDX_W-1:0] idx_o
);
  localparam logic [IDX_W-1:0] LastIdx = IDX_W'(RING_ENTRIES - 1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    idx_o <= '0;
    else if (adv_i) idx_o <= (idx_o == LastIdx) ? '0 : idx_o + 1'b1;
  end
endmodule

// File: rtl/rx_seq_fsm.sv
module rx_seq_fsm
  import rx_dma_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      start_i,
  input  logic      stop_i,
  input  logic      poll_i,
  input  logic      ts_en_i,
  input  logic      fetch_ack_i,
  input  logic      fetch_own_i,
  input  logic      fetch_irq_dis_i,
  input  logic      frame_avail_i,
  input  logic      xfer_done_i,
  input  logic      xfer_eof_i,
  output rx_state_e state_o,
  output logic      adv_o,
  output logic      ru_evt_o,
  output logic      stop_evt_o,
  output logic      rc_evt_o,
  output logic      early_evt_o
);
  rx_state_e st_q, st_d;
  logic stop_pend_q, in_frame_q, first_q, eof_q, irq_dis_q, prev_own_q;
  logic stop_req, ru_d, stp_d, rc_d, er_d, adv;

  assign stop_req = stop_i | stop_pend_q;

  always_comb begin
    st_d = st_q;
    ru_d = 1'b0;
    rc_d = 1'b0;
    er_d = 1'b0;
    adv  = 1'b0;
    unique case (st_q)
      RX_STOPPED: if (start_i && !stop_i) st_d = RX_FETCH;
      RX_FETCH: if (fetch_ack_i) begin
        if (stop_req)         st_d = RX_STOPPED;
        else if (fetch_own_i) st_d = in_frame_q ? RX_XFER : RX_WAIT;
        else begin
          st_d = RX_SUSP;
          ru_d = prev_own_q;
        end
      end
      RX_WAIT: begin
        if (stop_req)           st_d = RX_STOPPED;
        else if (frame_avail_i) st_d = RX_XFER;
      end
      RX_XFER: if (xfer_done_i) begin
        st_d = (xfer_eof_i && ts_en_i) ? RX_TSWR : RX_CLOSE;
        er_d = first_q && !xfer_eof_i;
      end
      RX_TSWR: st_d = RX_CLOSE;
      RX_CLOSE: begin
        adv  = 1'b1;
        rc_d = eof_q && !irq_dis_q;
        st_d = stop_req ? RX_STOPPED : RX_FETCH;
      end
      RX_SUSP: begin
        if (stop_req)                    st_d = RX_STOPPED;
        else if (poll_i || frame_avail_i) st_d = RX_FETCH;
      end
      default: st_d = RX_STOPPED;
    endcase
    stp_d = (st_d == RX_STOPPED) && (st_q != RX_STOPPED);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q        <= RX_STOPPED;
      stop_pend_q <= 1'b0;
      in_frame_q  <= 1'b0;
      first_q     <= 1'b0;
      eof_q       <= 1'b0;
      irq_dis_q   <= 1'b0;
      prev_own_q  <= 1'b1;
      ru_evt_o    <= 1'b0;
      stop_evt_o  <= 1'b0;
      rc_evt_o    <= 1'b0;
      early_evt_o <= 1'b0;
    end else begin
      st_q        <= st_d;
      ru_evt_o    <= ru_d;
      stop_evt_o  <= stp_d;
      rc_evt_o    <= rc_d;
      early_evt_o <= er_d;
      // stop request waits for a state boundary
      if (st_d == RX_STOPPED)                 stop_pend_q <= 1'b0;
      else if (stop_i && st_q != RX_STOPPED)  stop_pend_q <= 1'b1;
      if (st_d == RX_STOPPED)                 in_frame_q <= 1'b0;
      else if (st_q == RX_XFER && xfer_done_i) in_frame_q <= !xfer_eof_i;
      if (st_q == RX_WAIT && st_d == RX_XFER) first_q <= 1'b1;
      else if (st_q == RX_XFER && xfer_done_i) first_q <= 1'b0;
      if (st_q == RX_XFER && xfer_done_i)     eof_q <= xfer_eof_i;
      if (st_q == RX_FETCH && fetch_ack_i) begin
        irq_dis_q  <= fetch_irq_dis_i;
        prev_own_q <= fetch_own_i;
      end
    end
  end

  assign state_o = st_q;
  assign adv_o   = adv;
endmodule

// File: rtl/rx_dma_seq.sv
module rx_dma_seq
  import rx_dma_pkg::*;
#(
  parameter int unsigned RING_ENTRIES = 5,
  localparam int unsigned IDX_W = (RING_ENTRIES > 1) ? $clog2(RING_ENTRIES) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             stop_i,
  input  logic             poll_i,
  input  logic             ts_en_i,
  output logic             fetch_req_o,
  input  logic             fetch_ack_i,
  input  logic             fetch_own_i,
  input  logic             fetch_irq_dis_i,
  input  logic             frame_avail_i,
  input  logic             xfer_done_i,
  input  logic             xfer_eof_i,
  output logic [2:0]       state_o,
  output logic [IDX_W-1:0] desc_idx_o,
  output logic             ru_evt_o,
  output logic             stop_evt_o,
  output logic             rc_evt_o,
  output logic             early_evt_o
);
  rx_state_e st;
  logic      adv;

  rx_seq_fsm u_fsm (
    .clk_i, .rst_ni, .start_i, .stop_i, .poll_i, .ts_en_i,
    .fetch_ack_i, .fetch_own_i, .fetch_irq_dis_i, .frame_avail_i,
    .xfer_done_i, .xfer_eof_i,
    .state_o(st), .adv_o(adv),
    .ru_evt_o, .stop_evt_o, .rc_evt_o, .early_evt_o
  );

  rx_ring_ptr #(.RING_ENTRIES(RING_ENTRIES)) u_ptr (
    .clk_i, .rst_ni, .adv_i(adv), .idx_o(desc_idx_o)
  );

  assign state_o     = st;
  assign fetch_req_o = (st == RX_FETCH);
endmodule

// File: rtl/rx_dma_seq_chk.sv
module rx_dma_seq_chk
  import rx_dma_pkg::*;
#(
  parameter int unsigned RING_ENTRIES = 5,
  localparam int unsigned IDX_W = (RING_ENTRIES > 1) ? $clog2(RING_ENTRIES) : 1
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             start_i,
  input logic             stop_i,
  input logic             poll_i,
  input logic             ts_en_i,
  input logic             frame_avail_i,
  input logic             xfer_done_i,
  input logic [2:0]       state_o,
  input logic [IDX_W-1:0] desc_idx_o,
  input logic             ru_evt_o,
  input logic             stop_evt_o,
  input logic             rc_evt_o,
  input logic             early_evt_o
);
  localparam logic [IDX_W-1:0] LastIdx = IDX_W'(RING_ENTRIES - 1);

  a_r1_code_legal: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_o != 3'b010);
  a_r2_start: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_o == RX_STOPPED && start_i && !stop_i) |=> state_o == RX_FETCH);
  a_r4_ru_in_susp: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ru_evt_o |-> state_o == RX_SUSP);
  a_r5_susp_wake: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_o == RX_SUSP && !stop_i && (poll_i || frame_avail_i)) |=> state_o == RX_FETCH);
  a_r6_xfer_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_o == RX_XFER && !xfer_done_i) |=> state_o == RX_XFER);
  a_r7_ts_gated: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_o == RX_TSWR |-> $past(ts_en_i));
  a_r8_rc_after_close: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rc_evt_o |-> $past(state_o) == RX_CLOSE);
  a_r9_early_in_close: assert property (@(posedge clk_i) disable iff (!rst_ni)
    early_evt_o |-> state_o == RX_CLOSE);
  a_r10_stop_evt: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_evt_o |-> (state_o == RX_STOPPED && $past(state_o) != RX_STOPPED));
  a_r11_ptr_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_o == RX_CLOSE |=>
      desc_idx_o == (($past(desc_idx_o) == LastIdx) ? '0 : $past(desc_idx_o) + 1'b1));
  a_r11_ptr_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_o != RX_CLOSE |=> $stable(desc_idx_o));
endmodule

bind rx_dma_seq rx_dma_seq_chk #(.RING_ENTRIES(RING_ENTRIES)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i), .stop_i(stop_i),
  .poll_i(poll_i), .ts_en_i(ts_en_i), .frame_avail_i(frame_avail_i),
  .xfer_done_i(xfer_done_i), .state_o(state_o), .desc_idx_o(desc_idx_o),
  .ru_evt_o(ru_evt_o), .stop_evt_o(stop_evt_o), .rc_evt_o(rc_evt_o),
  .early_evt_o(early_evt_o)
);

// File: tb/tb_rx_dma_seq.sv
module tb_rx_dma_seq;
  localparam int RING = 5;
  localparam int IW = $clog2(RING);
  localparam int S_STOP = 0, S_FETCH = 1, S_WAIT = 3, S_SUSP = 4,
                 S_CLOSE = 5, S_TS = 6, S_XFER = 7;

  logic clk_i = 1'b0, rst_ni = 1'b0;
  logic start_i = 0, stop_i = 0, poll_i = 0, ts_en_i = 0;
  logic fetch_ack_i = 0, fetch_own_i = 0, fetch_irq_dis_i = 0;
  logic frame_avail_i = 0, xfer_done_i = 0, xfer_eof_i = 0;
  logic fetch_req_o, ru_evt_o, stop_evt_o, rc_evt_o, early_evt_o;
  logic [2:0] state_o;
  logic [IW-1:0] desc_idx_o;

  int n_chk = 0, n_fail = 0, cyc = 0;
  int exp_idx = 0;
  bit last_irqd = 0;
  bit done = 0;

  rx_dma_seq #(.RING_ENTRIES(RING)) dut (.*);

  always #5 clk_i = ~clk_i;

  always @(posedge clk_i) begin
    cyc++;
    if (cyc > 20000 && !done) begin
      done = 1;
      n_fail++;
      $display("FAIL watchdog: actual cycles %0d expected < 20000", cyc);
      $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk_i);
    #1;
  endtask

  task automatic do_fetch(input bit own, input bit irqd, input int nxt, input bit ru);
    chk("R2 fetch_req", fetch_req_o, 1);
    fetch_ack_i = 1; fetch_own_i = own; fetch_irq_dis_i = irqd;
    tick();
    fetch_ack_i = 0; fetch_own_i = 0; fetch_irq_dis_i = 0;
    last_irqd = irqd;
    chk(own ? "R3 fetch owned" : "R4 fetch host", state_o, nxt);
    chk("R4 ru_evt", ru_evt_o, ru);
  endtask

  task automatic run_frame(input int nbuf, input bit ts, input bit irqd);
    ts_en_i = ts;
    frame_avail_i = 1;
    tick();
    frame_avail_i = 0;
    chk("R6 wait->xfer", state_o, S_XFER);
    for (int b = 0; b < nbuf; b++) begin
      bit last;
      last = (b == nbuf - 1);
      for (int k = 0; k < 2; k++) begin
        tick();
        chk("R6 xfer hold", state_o, S_XFER);
      end
      xfer_done_i = 1; xfer_eof_i = last;
      tick();
      xfer_done_i = 0; xfer_eof_i = 0;
      if (last && ts) begin
        chk("R7 ts state", state_o, S_TS);
        chk("R9 no early in ts", early_evt_o, 0);
        tick();
      end
      chk("R7 close", state_o, S_CLOSE);
      chk("R9 early_evt", early_evt_o, (b == 0 && !last) ? 1 : 0);
      chk("R11 idx in close", desc_idx_o, exp_idx);
      tick();
      exp_idx = (exp_idx + 1) % RING;
      chk("R8 close->fetch", state_o, S_FETCH);
      chk("R8 rc_evt", rc_evt_o, (last && !last_irqd) ? 1 : 0);
      chk("R11 idx step", desc_idx_o, exp_idx);
      do_fetch(1, irqd, last ? S_WAIT : S_XFER, 0);
    end
  endtask

  initial begin
    repeat (2) @(posedge clk_i);
    #1 rst_ni = 1;
    chk("R1 reset state", state_o, S_STOP);
    chk("R1 reset idx", desc_idx_o, 0);
    chk("R1 reset events", {ru_evt_o, stop_evt_o, rc_evt_o, early_evt_o}, 0);
    poll_i = 1; frame_avail_i = 1;
    tick();
    poll_i = 0; frame_avail_i = 0;
    chk("R2 ignored while stopped", state_o, S_STOP);
    start_i = 1;
    tick();
    start_i = 0;
    chk("R2 start", state_o, S_FETCH);
    do_fetch(1, 0, S_WAIT, 0);

    // sweep: timestamp enable x irq disable x buffers per frame
    for (int t = 0; t < 2; t++)
      for (int d = 0; d < 2; d++)
        for (int n = 1; n <= 3; n++)
          run_frame(n, t[0], d[0]);

    // stop while waiting
    stop_i = 1;
    tick();
    stop_i = 0;
    chk("R10 stop in wait", state_o, S_STOP);
    chk("R10 stop_evt", stop_evt_o, 1);
    tick();
    chk("R10 stop_evt one cycle", stop_evt_o, 0);
    stop_i = 1;
    tick();
    stop_i = 0;
    chk("R10 no evt when stopped", stop_evt_o, 0);
    start_i = 1; stop_i = 1;
    tick();
    start_i = 0; stop_i = 0;
    chk("R2 start+stop stays", state_o, S_STOP);
    start_i = 1;
    tick();
    start_i = 0;
    chk("R2 restart", state_o, S_FETCH);
    chk("R11 idx kept on restart", desc_idx_o, exp_idx);

    // suspension paths
    do_fetch(0, 0, S_SUSP, 1);
    tick();
    chk("R5 stays suspended", state_o, S_SUSP);
    chk("R4 ru one cycle", ru_evt_o, 0);
    poll_i = 1;
    tick();
    poll_i = 0;
    chk("R5 poll wake", state_o, S_FETCH);
    chk("R5 same idx", desc_idx_o, exp_idx);
    do_fetch(0, 0, S_SUSP, 0);
    frame_avail_i = 1;
    tick();
    frame_avail_i = 0;
    chk("R5 frame wake", state_o, S_FETCH);
    do_fetch(1, 0, S_WAIT, 0);

    // stop during transfer finishes through close
    ts_en_i = 1;
    frame_avail_i = 1;
    tick();
    frame_avail_i = 0;
    stop_i = 1;
    tick();
    stop_i = 0;
    chk("R10 xfer not stopped", state_o, S_XFER);
    tick();
    chk("R10 xfer still running", state_o, S_XFER);
    xfer_done_i = 1; xfer_eof_i = 1;
    tick();
    xfer_done_i = 0; xfer_eof_i = 0;
    chk("R7 ts before stop", state_o, S_TS);
    tick();
    chk("R10 close before stop", state_o, S_CLOSE);
    tick();
    exp_idx = (exp_idx + 1) % RING;
    chk("R10 stop after close", state_o, S_STOP);
    chk("R10 stop_evt after close", stop_evt_o, 1);
    chk("R8 rc with stop", rc_evt_o, 1);
    chk("R11 idx after close", desc_idx_o, exp_idx);

    // stop during fetch waits for ack
    start_i = 1;
    tick();
    start_i = 0;
    stop_i = 1;
    tick();
    stop_i = 0;
    chk("R10 fetch not stopped", state_o, S_FETCH);
    do_fetch(1, 0, S_STOP, 0);
    chk("R10 stop_evt at ack", stop_evt_o, 1);
    chk("R11 idx unchanged by fetch", desc_idx_o, exp_idx);

    // stop while suspended
    start_i = 1;
    tick();
    start_i = 0;
    do_fetch(0, 0, S_SUSP, 1);
    stop_i = 1;
    tick();
    stop_i = 0;
    chk("R10 stop in suspend", state_o, S_STOP);
    chk("R10 stop_evt from suspend", stop_evt_o, 1);

    done = 1;
    $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule